// File: doc/BRIEF.md
# DMA Channel Transfer-Mode Controller

This block holds the per-channel transfer configuration of a four-channel DMA engine. It decides, for the channel now being serviced, whether service goes on after each transfer or stops. Software loads a packed mode byte. The low bits of that byte pick the channel it lands in, and the upper six bits set the termination rule, the transfer direction, the address step direction and automatic reinitialisation.

While a channel holds its acknowledge, the block watches four inputs: the request line, the per-transfer completion pulse qualified by ready, terminal count and the active-low end-of-process input. Each mode has its own rule for ending service. Demand mode stops when the request falls. Single mode stops after one transfer. Block mode runs until terminal count or end-of-process. Cascade mode passes control through to a downstream controller. The block keeps a continue flag high while service goes on and gives a one-cycle end pulse when service stops. When service stops on terminal count with auto-initialisation enabled, it also gives a one-cycle reload strobe, so that the surrounding logic can restore the base address and count. Bus timing and channel arbitration are handled elsewhere.

Top module: `dma_mode_ctrl`

## Requirements
- R1: After reset every channel reads back demand mode, verify type (`xfer_type` = 00), increment direction (`addr_dec` = 0) and auto-init off. `svc_cont`, `svc_end` and `reload` are all 0.
- R2: A write with `mode_wr` high stores `mode_byte[7:2]` only into the channel numbered by `mode_byte[1:0]`. The other three channels keep their settings.
- R3: For the channel on `svc_ch`, `addr_dec` equals stored bit 5, and `xfer_type` equals stored bits 3:2 (00 verify, 01 I/O to memory, 10 memory to I/O, 11 illegal, reported as stored). In cascade mode (bits 7:6 = 11), `xfer_type` reads 00.
- R4: Demand mode (bits 7:6 = 00) keeps `svc_cont` high through completed transfers that have no terminal count. Service ends when `dreq` is low while `dack` is high.
- R5: Single mode (bits 7:6 = 01) ends service on the first completed transfer.
- R6: Block mode (bits 7:6 = 10) ignores `dreq` going low and ends service only on terminal count or end-of-process.
- R7: In demand, single and block modes, `eop_n` low while `dack` is high ends service.
- R8: In non-cascade modes, a `xfer_done` pulse while `ready` is low does not count as a completed transfer. It neither ends single service nor honours `tc`.
- R9: In cascade mode, service ends only when `dreq` falls. `ready`, `tc`, `eop_n` and `xfer_done` have no effect.
- R10: `reload` pulses for one cycle together with `svc_end` only when service ends on a completed transfer with `tc` high and auto-init (bit 4) set. An end caused only by end-of-process gives no reload.
- R11: `svc_end` and `svc_cont` are registered one cycle after their cause. `svc_end` is a single-cycle pulse per service, and `svc_cont` is never high in the same cycle. After an end, `svc_cont` stays low until `dack` has been low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Mode byte write strobe |
| mode_byte | input | 8 | Packed mode byte, bits 1:0 channel number |
| svc_ch | input | 2 | Channel currently being serviced |
| dreq | input | 1 | Request line of the serviced channel, active high |
| dack | input | 1 | Acknowledge state of the serviced channel, active high |
| xfer_done | input | 1 | One-cycle pulse at the end of each transfer |
| ready | input | 1 | Transfer-ready qualifier |
| tc | input | 1 | Terminal count reached on this transfer |
| eop_n | input | 1 | External end-of-process, active low |
| svc_cont | output | 1 | Service continues after this cycle |
| svc_end | output | 1 | One-cycle end-of-service pulse |
| addr_dec | output | 1 | Address steps downward |
| xfer_type | output | 2 | Transfer type of serviced channel |
| reload | output | 1 | One-cycle base address and count reload strobe |

## Verification
Terminal count and external end-of-process can arrive in the same cycle, because both can end a block-mode service. The bench raises `xfer_done`, `ready`, `tc` and a low `eop_n` together on a block-mode channel with auto-init set. It then expects exactly one `svc_end` pulse with `reload` in the same cycle, and a quiet cycle after that. This combined case is set against a pure end-of-process end, which must leave `reload` low.

// File: rtl/dma_mode_pkg.sv
// Package: shared types for the DMA transfer-mode controller.
// Assumes the stored mode field order matches mode byte bits 7:2.
package dma_mode_pkg;

    typedef enum logic [1:0] {
        MD_DEMAND  = 2'b00,
        MD_SINGLE  = 2'b01,
        MD_BLOCK   = 2'b10,
        MD_CASCADE = 2'b11
    } xfer_mode_e;

    // Field order equals mode byte bits 7:6, 5, 4, 3:2.
    typedef struct packed {
        xfer_mode_e mode;
        logic       dec;
        logic       autoinit;
        logic [1:0] xtype;
    } chan_mode_t;

    localparam int MODE_FIELD_W = $bits(chan_mode_t);

endpackage

// File: rtl/dma_mode_regs.sv
// Module: per-channel mode register file with a read port for the
// serviced channel. Assumes one write per cycle and a channel number
// carried in the low bits of the written byte.
module dma_mode_regs
    import dma_mode_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int BYTE_W = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [CH_W-1:0]   rd_ch,
    output chan_mode_t        rd_cfg
);

    chan_mode_t cfg_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Load this channel when the write addresses it; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (wr_en && (wr_byte[CH_W-1:0] == CH_W'(g))) begin
                cfg_q[g] <= chan_mode_t'(wr_byte[BYTE_W-1 -: MODE_FIELD_W]);
            end
        end
    end

    // Select the configuration of the serviced channel.
    always_comb begin
        rd_cfg = cfg_q[rd_ch];
    end

endmodule

// File: rtl/dma_end_detect.sv
// Module: combinational termination rule for the serviced channel.
// Assumes inputs are already synchronous to clk; eop_n is active low.
module dma_end_detect
    import dma_mode_pkg::*;
(
    input  xfer_mode_e mode,
    input  logic       dack,
    input  logic       dreq,
    input  logic       xfer_done,
    input  logic       ready,
    input  logic       tc,
    input  logic       eop_n,
    output logic       end_now,
    output logic       tc_end
);

    logic done_ok;
    logic eop;

    // Qualify a completed transfer and decode the per-mode stop rule.
    always_comb begin
        done_ok = xfer_done && ready;
        eop     = !eop_n;
        tc_end  = 1'b0;
        end_now = 1'b0;
        if (dack) begin
            unique case (mode)
                MD_DEMAND: begin
                    tc_end  = done_ok && tc;
                    end_now = tc_end || eop || !dreq;
                end
                MD_SINGLE: begin
                    tc_end  = done_ok && tc;
                    end_now = done_ok || eop;
                end
                MD_BLOCK: begin
                    tc_end  = done_ok && tc;
                    end_now = tc_end || eop;
                end
                MD_CASCADE: begin
                    end_now = !dreq;
                end
                default: begin
                    end_now = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dma_svc_seq.sv
// Module: registers the service flags. Gives one end pulse per service
// and holds continue low until acknowledge has dropped.
module dma_svc_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic dack,
    input  logic end_now,
    input  logic tc_end,
    input  logic autoinit,
    output logic svc_cont,
    output logic svc_end,
    output logic reload
);

    logic ended_q;
    logic fire;

    // An end is taken only once per acknowledge period.
    always_comb begin
        fire = dack && end_now && !ended_q;
    end

    // Track that service ended while acknowledge is still high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ended_q <= 1'b0;
        end else if (!dack) begin
            ended_q <= 1'b0;
        end else if (end_now) begin
            ended_q <= 1'b1;
        end
    end

    // Register the continue, end and reload outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_cont <= 1'b0;
            svc_end  <= 1'b0;
            reload   <= 1'b0;
        end else begin
            svc_cont <= dack && !ended_q && !end_now;
            svc_end  <= fire;
            reload   <= fire && tc_end && autoinit;
        end
    end

endmodule

// File: rtl/dma_mode_ctrl.sv
// Module: top of the DMA transfer-mode controller. Stores four mode
// bytes and applies the serviced channel's rule for ending service.
// Assumes svc_ch is stable while dack is high.
module dma_mode_ctrl
    import dma_mode_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int BYTE_W = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [BYTE_W-1:0] mode_byte,
    input  logic [CH_W-1:0]   svc_ch,
    input  logic              dreq,
    input  logic              dack,
    input  logic              xfer_done,
    input  logic              ready,
    input  logic              tc,
    input  logic              eop_n,
    output logic              svc_cont,
    output logic              svc_end,
    output logic              addr_dec,
    output logic [1:0]        xfer_type,
    output logic              reload
);

    chan_mode_t cfg;
    logic       end_now;
    logic       tc_end;

    dma_mode_regs #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .wr_byte (mode_byte),
        .rd_ch   (svc_ch),
        .rd_cfg  (cfg)
    );

    dma_end_detect u_end (
        .mode      (cfg.mode),
        .dack      (dack),
        .dreq      (dreq),
        .xfer_done (xfer_done),
        .ready     (ready),
        .tc        (tc),
        .eop_n     (eop_n),
        .end_now   (end_now),
        .tc_end    (tc_end)
    );

    dma_svc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .dack     (dack),
        .end_now  (end_now),
        .tc_end   (tc_end),
        .autoinit (cfg.autoinit),
        .svc_cont (svc_cont),
        .svc_end  (svc_end),
        .reload   (reload)
    );

    // Report direction and type; type is masked in cascade mode.
    always_comb begin
        addr_dec  = cfg.dec;
        xfer_type = (cfg.mode == MD_CASCADE) ? 2'b00 : cfg.xtype;
    end

endmodule

// File: rtl/dma_mode_ctrl_chk.sv
// Module: assertion checker for dma_mode_ctrl, attached by bind.
module dma_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic dack,
    input logic tc,
    input logic svc_cont,
    input logic svc_end,
    input logic reload
);

    // R11
    end_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_end |=> !svc_end);

    // R11
    end_cont_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(svc_end && svc_cont));

    // R11
    no_ack_no_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dack |=> !svc_cont);

    // R10
    reload_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |-> svc_end);

    // R10
    reload_after_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reload) |-> $past(tc));

endmodule

bind dma_mode_ctrl dma_mode_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dack     (dack),
    .tc       (tc),
    .svc_cont (svc_cont),
    .svc_end  (svc_end),
    .reload   (reload)
);

// File: tb/dma_mode_ctrl_tb.sv
module dma_mode_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_byte = '0;
    logic [1:0] svc_ch = '0;
    logic       dreq = 1'b0;
    logic       dack = 1'b0;
    logic       xfer_done = 1'b0;
    logic       ready = 1'b1;
    logic       tc = 1'b0;
    logic       eop_n = 1'b1;
    logic       svc_cont, svc_end, addr_dec, reload;
    logic [1:0] xfer_type;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dma_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_byte(mode_byte),
        .svc_ch(svc_ch), .dreq(dreq), .dack(dack), .xfer_done(xfer_done),
        .ready(ready), .tc(tc), .eop_n(eop_n), .svc_cont(svc_cont),
        .svc_end(svc_end), .addr_dec(addr_dec), .xfer_type(xfer_type),
        .reload(reload)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one cycle: inputs set before this call are seen at the posedge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_mode(input logic [7:0] b);
        mode_wr = 1'b1; mode_byte = b; step();
        mode_wr = 1'b0; mode_byte = '0;
    endtask

    task automatic idle();
        dack = 0; dreq = 0; xfer_done = 0; tc = 0; eop_n = 1; ready = 1;
        step(); step();
    endtask

    task automatic t_reset();
        chk("R1 cont", svc_cont, 0);
        chk("R1 end", svc_end, 0);
        chk("R1 reload", reload, 0);
        for (int c = 0; c < 4; c++) begin
            svc_ch = 2'(c); #1;
            chk("R1 type", xfer_type, 0);
            chk("R1 dec", addr_dec, 0);
        end
    endtask

    task automatic t_write();
        write_mode(8'b01_1_1_10_10);          // ch2 single, dec, autoinit, read
        svc_ch = 2; #1;
        chk("R2 ch2 type", xfer_type, 2);
        chk("R3 ch2 dec", addr_dec, 1);
        svc_ch = 1; #1;
        chk("R2 ch1 untouched type", xfer_type, 0);
        chk("R2 ch1 untouched dec", addr_dec, 0);
        write_mode(8'b01_0_0_11_00);          // ch0 single, illegal type
        svc_ch = 0; #1;
        chk("R3 illegal type kept", xfer_type, 3);
        svc_ch = 2; #1;
        chk("R2 ch2 kept after ch0 write", xfer_type, 2);
    endtask

    task automatic t_demand();
        write_mode(8'b00_0_0_01_00);          // ch0 demand, write
        svc_ch = 0; #1;
        chk("R3 write type", xfer_type, 1);
        dack = 1; dreq = 1; step();
        chk("R4 cont start", svc_cont, 1);
        xfer_done = 1; step(); xfer_done = 0;
        chk("R4 cont after xfer", svc_cont, 1);
        chk("R4 no end", svc_end, 0);
        dreq = 0; step();
        chk("R4 end on dreq low", svc_end, 1);
        chk("R11 cont low at end", svc_cont, 0);
        step();
        chk("R11 end one pulse", svc_end, 0);
        chk("R11 cont stays low", svc_cont, 0);
        idle();
    endtask

    task automatic t_single();
        svc_ch = 2; dack = 1; dreq = 1; step();
        chk("R5 cont", svc_cont, 1);
        xfer_done = 1; ready = 0; step();
        chk("R8 not ready no end", svc_end, 0);
        chk("R8 not ready cont", svc_cont, 1);
        ready = 1; step(); xfer_done = 0;
        chk("R5 end after one", svc_end, 1);
        chk("R10 no reload w/o tc", reload, 0);
        idle();
    endtask

    task automatic t_block();
        write_mode(8'b10_0_1_01_01);          // ch1 block, autoinit
        svc_ch = 1; dack = 1; dreq = 1; step();
        dreq = 0; step();
        chk("R6 dreq low ignored", svc_cont, 1);
        xfer_done = 1; tc = 1; ready = 0; step();
        chk("R8 tc not honoured w/o ready", svc_end, 0);
        ready = 1; step(); xfer_done = 0; tc = 0;
        chk("R6 end on tc", svc_end, 1);
        chk("R10 reload", reload, 1);
        step();
        chk("R10 reload one cycle", reload, 0);
        idle();
    endtask

    task automatic t_eop();
        svc_ch = 1; dack = 1; dreq = 1; step();
        eop_n = 0; step(); eop_n = 1;
        chk("R7 end on eop", svc_end, 1);
        chk("R10 no reload on eop", reload, 0);
        idle();
        dack = 1; step();
        chk("R11 cont after dack cycle", svc_cont, 1);
        idle();
    endtask

    task automatic t_coincide();
        svc_ch = 1; dack = 1; dreq = 1; step();
        xfer_done = 1; tc = 1; eop_n = 0; step();
        xfer_done = 0; tc = 0; eop_n = 1;
        chk("R7 end tc+eop", svc_end, 1);
        chk("R10 reload tc+eop", reload, 1);
        step();
        chk("R11 single end tc+eop", svc_end, 0);
        idle();
    endtask

    task automatic t_cascade();
        write_mode(8'b11_0_0_10_11);          // ch3 cascade
        svc_ch = 3; #1;
        chk("R3 cascade type 00", xfer_type, 0);
        dack = 1; dreq = 1; step();
        xfer_done = 1; tc = 1; eop_n = 0; ready = 0; step();
        chk("R9 cascade ignores tc/eop", svc_end, 0);
        chk("R9 cascade cont", svc_cont, 1);
        xfer_done = 0; tc = 0; eop_n = 1; ready = 1;
        dreq = 0; step();
        chk("R9 cascade end on dreq", svc_end, 1);
        chk("R9 cascade no reload", reload, 0);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_write();
        t_demand();
        t_single();
        t_block();
        t_eop();
        t_coincide();
        t_cascade();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule